// File: doc/BRIEF.md
# Board control register file

This block is the control and status register file of a development board. A host reaches it through a simple 32-bit bus. Each access is a single-cycle strobe with a write flag. Only the low 20 bits of the address select a register, so any higher address bits alias onto the same window. The block holds:

- an 8-bit LED bar;
- an eight-character ASCII display buffer;
- a break/reset byte and a general-purpose output byte;
- a group of bit-banged I2C registers that drive a serial EEPROM slave elsewhere on the board.

The display buffer can be filled in two ways. A single word write renders a 32-bit value as eight uppercase hexadecimal characters. Per-position registers overwrite one character each. A write of one magic value to the soft-reset register pulses a system reset request. A read returns its data one cycle after the strobe. Writes produce no response.

Top module: `board_ctrl_regs`

## Requirements
- R1: A read strobe (`bus_valid`=1, `bus_write`=0) sampled at a clock edge sets `bus_rvalid` high for exactly the following cycle, with that read's data on `bus_rdata`. Write strobes and idle cycles leave `bus_rvalid` low.
- R2: Only address bits 19:0 are decoded, so higher bits are ignored. Reads of an offset with no register return zero. Writes to such an offset change no register.
- R3: The switch register (offset 0x200) and the jumper register (offset 0x210) always read zero. Writes to them are discarded.
- R4: The status register (offset 0x208) reads 0x12 when parameter `BIG_ENDIAN` is 1 and 0x10 when it is 0.
- R5: The LED register (offset 0x408) stores the low 8 bits of a write, drives them on `led_bar` from the cycle after the write, reads them back, and resets to zero.
- R6: A write to offset 0x410 replaces all eight display characters with the uppercase ASCII hex digits of the written word. Nibble 31:28 goes to position 0, and nibble 3:0 goes to position 7. Position i appears on `disp_text[8i+7:8i]`. After reset every position holds a space (0x20).
- R7: A write to offset 0x418+8·i (i = 0..7) sets display position i to the low byte written. Offsets between those registers that are not multiples of 8 are unmapped. The display registers read as zero.
- R8: A write of exactly 0x00000042 to offset 0x500 drives `sys_reset_req` high for the single cycle after the write. Any other value, and any other cycle, leaves it low.
- R9: The break/reset register (offset 0x508) holds 8 bits and resets to 0x0A. The general-purpose output register (offset 0xA00) holds 8 bits, resets to zero and drives `gp_out`.
- R10: The I2C output register (offset 0xB10) stores the full written word and resets to 3. Bit 1 drives `i2c_scl` and bit 0 drives `i2c_sda`. `i2c_update` pulses for the one cycle after each write to it.
- R11: The I2C input register (offset 0xB00) reads bit 0 as the live `i2c_sda_in` level at the read strobe, bit 1 as 1, and all other bits as 0.
- R12: The I2C output-enable register (offset 0xB08) holds 2 bits, resets to 0 and drives `i2c_oe`. The I2C select register (offset 0xB18) holds 1 bit and resets to 1.
- R13: The general-purpose input register (offset 0xA08) reads the I2C output register value when the select bit is 1, and zero when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; bits 19:0 are decoded |
| bus_wdata | input | DATA_W | Write data |
| bus_rvalid | output | 1 | Read data valid, cycle after a read strobe |
| bus_rdata | output | DATA_W | Read data |
| sys_reset_req | output | 1 | One-cycle system reset request |
| led_bar | output | LED_W | LED bar state |
| gp_out | output | GPO_W | General-purpose output |
| disp_text | output | 8·NUM_CHARS | Display characters, position 0 in the low byte |
| i2c_scl | output | 1 | I2C clock level to the EEPROM slave |
| i2c_sda | output | 1 | I2C data level to the EEPROM slave |
| i2c_oe | output | 2 | I2C output-enable bits |
| i2c_update | output | 1 | Pulses after each write of the I2C output register |
| i2c_sda_in | input | 1 | Data level returned by the EEPROM slave |

## Verification
The bench checks the following corner cases, each of which a faulty design would get visibly wrong:

- **Address aliasing.** An address with high bits set must still hit its register. An offset four bytes below the LED register must not hit it. A design decoding too many or too few bits would lose the aliased write or corrupt the LED bar.
- **Magic-value comparison.** The soft-reset value is tried with its neighbour and with extra high bits. A design comparing only the low byte would fire on 0x142. A design that stretched the pulse would still show it a cycle later.
- **Hex rendering.** Word writes are checked nibble by nibble, including the A–F digits and the nibble order. A reversed or lowercase rendering mismatches at once.
- **Character spacing.** A write at an offset between two character registers must be ignored.
- **Input mirroring.** The general-purpose input is read with the select bit both set and cleared.
- **Live data bit.** The I2C input is read with the slave data line at both levels, which catches a stale or missing bit 0.

// File: rtl/board_ctrl_pkg.sv
package board_ctrl_pkg;

  localparam int OFF_W = 20;

  localparam int unsigned OFF_SWITCH  = 32'h0_0200;
  localparam int unsigned OFF_STATUS  = 32'h0_0208;
  localparam int unsigned OFF_JUMPER  = 32'h0_0210;
  localparam int unsigned OFF_LED     = 32'h0_0408;
  localparam int unsigned OFF_HEXWORD = 32'h0_0410;
  localparam int unsigned OFF_CHAR0   = 32'h0_0418;
  localparam int unsigned OFF_SOFTRST = 32'h0_0500;
  localparam int unsigned OFF_BRK     = 32'h0_0508;
  localparam int unsigned OFF_GPOUT   = 32'h0_0A00;
  localparam int unsigned OFF_GPIN    = 32'h0_0A08;
  localparam int unsigned OFF_I2C_IN  = 32'h0_0B00;
  localparam int unsigned OFF_I2C_OE  = 32'h0_0B08;
  localparam int unsigned OFF_I2C_OUT = 32'h0_0B10;
  localparam int unsigned OFF_I2C_SEL = 32'h0_0B18;

  localparam int unsigned SOFTRST_MAGIC = 32'h0000_0042;
  localparam logic [7:0]  ASCII_SPACE   = 8'h20;

  typedef enum logic [3:0] {
    RS_NONE,
    RS_SWITCH,
    RS_STATUS,
    RS_JUMPER,
    RS_LED,
    RS_HEXWORD,
    RS_CHAR,
    RS_SOFTRST,
    RS_BRK,
    RS_GPOUT,
    RS_GPIN,
    RS_I2C_IN,
    RS_I2C_OE,
    RS_I2C_OUT,
    RS_I2C_SEL
  } reg_sel_e;

  // Uppercase ASCII hex digit for one nibble.
  function automatic logic [7:0] nibble_to_ascii(input logic [3:0] n);
    if (n < 4'd10) return 8'h30 + {4'h0, n};
    else           return 8'h37 + {4'h0, n};
  endfunction

endpackage

// File: rtl/board_ctrl_decode.sv
module board_ctrl_decode
  import board_ctrl_pkg::*;
#(
  parameter int NUM_CHARS = 8,
  parameter int IDX_W     = (NUM_CHARS > 1) ? $clog2(NUM_CHARS) : 1
) (
  input  logic [OFF_W-1:0] offset,
  output reg_sel_e         sel,
  output logic [IDX_W-1:0] char_idx
);

  localparam int CHAR_SPAN = NUM_CHARS * 8;

  logic [OFF_W-1:0] rel;

  assign rel      = offset - OFF_W'(OFF_CHAR0);
  assign char_idx = rel[IDX_W+2:3];

  always_comb begin
    sel = RS_NONE;
    case (offset)
      OFF_W'(OFF_SWITCH):  sel = RS_SWITCH;
      OFF_W'(OFF_STATUS):  sel = RS_STATUS;
      OFF_W'(OFF_JUMPER):  sel = RS_JUMPER;
      OFF_W'(OFF_LED):     sel = RS_LED;
      OFF_W'(OFF_HEXWORD): sel = RS_HEXWORD;
      OFF_W'(OFF_SOFTRST): sel = RS_SOFTRST;
      OFF_W'(OFF_BRK):     sel = RS_BRK;
      OFF_W'(OFF_GPOUT):   sel = RS_GPOUT;
      OFF_W'(OFF_GPIN):    sel = RS_GPIN;
      OFF_W'(OFF_I2C_IN):  sel = RS_I2C_IN;
      OFF_W'(OFF_I2C_OE):  sel = RS_I2C_OE;
      OFF_W'(OFF_I2C_OUT): sel = RS_I2C_OUT;
      OFF_W'(OFF_I2C_SEL): sel = RS_I2C_SEL;
      default: begin
        // Offsets below the character window wrap to large values of rel.
        if (rel < OFF_W'(CHAR_SPAN) && rel[2:0] == 3'b000) sel = RS_CHAR;
      end
    endcase
  end

endmodule

// File: rtl/board_ctrl_display.sv
module board_ctrl_display
  import board_ctrl_pkg::*;
#(
  parameter int NUM_CHARS = 8,
  parameter int DATA_W    = 32,
  parameter int IDX_W     = (NUM_CHARS > 1) ? $clog2(NUM_CHARS) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_word,
  input  logic                   wr_char,
  input  logic [IDX_W-1:0]       char_idx,
  input  logic [DATA_W-1:0]      wdata,
  output logic [8*NUM_CHARS-1:0] text
);

  logic [7:0] chars [NUM_CHARS];

  for (genvar i = 0; i < NUM_CHARS; i++) begin : g_pos
    // Position 0 shows the most significant nibble of a word write.
    localparam int NIB_LSB = 4 * (NUM_CHARS - 1 - i);

    always_ff @(posedge clk) begin
      if (rst) begin
        chars[i] <= ASCII_SPACE;
      end else if (wr_word) begin
        chars[i] <= nibble_to_ascii(wdata[NIB_LSB +: 4]);
      end else if (wr_char && char_idx == IDX_W'(i)) begin
        chars[i] <= wdata[7:0];
      end
    end

    assign text[8*i +: 8] = chars[i];
  end

endmodule

// File: rtl/board_ctrl_i2c.sv
module board_ctrl_i2c #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_out,
  input  logic              wr_oe,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic              sda_in,
  output logic [DATA_W-1:0] out_word,
  output logic [DATA_W-1:0] in_word,
  output logic [1:0]        oe,
  output logic              sel,
  output logic              scl_o,
  output logic              sda_o,
  output logic              update
);

  logic [DATA_W-1:0] out_q;
  logic [DATA_W-1:0] held_q;
  logic [1:0]        oe_q;
  logic              sel_q;
  logic              upd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q  <= DATA_W'(3);
      held_q <= DATA_W'(3);
      oe_q   <= 2'b00;
      sel_q  <= 1'b1;
      upd_q  <= 1'b0;
    end else begin
      upd_q <= wr_out;
      if (wr_out) out_q <= wdata;
      if (wr_oe)  oe_q  <= wdata[1:0];
      if (wr_sel) sel_q <= wdata[0];
    end
  end

  assign out_word = out_q;
  assign in_word  = {held_q[DATA_W-1:1], sda_in};
  assign oe       = oe_q;
  assign sel      = sel_q;
  assign scl_o    = out_q[1];
  assign sda_o    = out_q[0];
  assign update   = upd_q;

endmodule

// File: rtl/board_ctrl_regs.sv
module board_ctrl_regs
  import board_ctrl_pkg::*;
#(
  parameter int         ADDR_W     = 32,
  parameter int         DATA_W     = 32,
  parameter int         NUM_CHARS  = 8,
  parameter int         LED_W      = 8,
  parameter int         GPO_W      = 8,
  parameter int         BRK_W      = 8,
  parameter logic [7:0] BRK_RESET  = 8'h0A,
  parameter bit         BIG_ENDIAN = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   bus_valid,
  input  logic                   bus_write,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [DATA_W-1:0]      bus_wdata,
  output logic                   bus_rvalid,
  output logic [DATA_W-1:0]      bus_rdata,
  output logic                   sys_reset_req,
  output logic [LED_W-1:0]       led_bar,
  output logic [GPO_W-1:0]       gp_out,
  output logic [8*NUM_CHARS-1:0] disp_text,
  output logic                   i2c_scl,
  output logic                   i2c_sda,
  output logic [1:0]             i2c_oe,
  output logic                   i2c_update,
  input  logic                   i2c_sda_in
);

  localparam int         IDX_W      = (NUM_CHARS > 1) ? $clog2(NUM_CHARS) : 1;
  localparam logic [7:0] STATUS_VAL = BIG_ENDIAN ? 8'h12 : 8'h10;

  logic              wr_en;
  logic              rd_en;
  reg_sel_e          sel;
  logic [IDX_W-1:0]  char_idx;
  logic [DATA_W-1:0] rd_mux;

  logic [LED_W-1:0]  led_q;
  logic [BRK_W-1:0]  brk_q;
  logic [GPO_W-1:0]  gpo_q;
  logic              rst_req_q;
  logic              rvalid_q;
  logic [DATA_W-1:0] rdata_q;

  logic [DATA_W-1:0] i2c_out_word;
  logic [DATA_W-1:0] i2c_in_word;
  logic [1:0]        i2c_oe_w;
  logic              i2c_sel_w;

  assign wr_en = bus_valid &  bus_write;
  assign rd_en = bus_valid & ~bus_write;

  board_ctrl_decode #(
    .NUM_CHARS (NUM_CHARS),
    .IDX_W     (IDX_W)
  ) u_decode (
    .offset   (bus_addr[OFF_W-1:0]),
    .sel      (sel),
    .char_idx (char_idx)
  );

  board_ctrl_display #(
    .NUM_CHARS (NUM_CHARS),
    .DATA_W    (DATA_W),
    .IDX_W     (IDX_W)
  ) u_display (
    .clk      (clk),
    .rst      (rst),
    .wr_word  (wr_en && sel == RS_HEXWORD),
    .wr_char  (wr_en && sel == RS_CHAR),
    .char_idx (char_idx),
    .wdata    (bus_wdata),
    .text     (disp_text)
  );

  board_ctrl_i2c #(
    .DATA_W (DATA_W)
  ) u_i2c (
    .clk      (clk),
    .rst      (rst),
    .wr_out   (wr_en && sel == RS_I2C_OUT),
    .wr_oe    (wr_en && sel == RS_I2C_OE),
    .wr_sel   (wr_en && sel == RS_I2C_SEL),
    .wdata    (bus_wdata),
    .sda_in   (i2c_sda_in),
    .out_word (i2c_out_word),
    .in_word  (i2c_in_word),
    .oe       (i2c_oe_w),
    .sel      (i2c_sel_w),
    .scl_o    (i2c_scl),
    .sda_o    (i2c_sda),
    .update   (i2c_update)
  );

  // Register storage for the simple byte registers and the reset pulse.
  always_ff @(posedge clk) begin
    if (rst) begin
      led_q     <= '0;
      brk_q     <= BRK_RESET[BRK_W-1:0];
      gpo_q     <= '0;
      rst_req_q <= 1'b0;
    end else begin
      rst_req_q <= wr_en && sel == RS_SOFTRST &&
                   bus_wdata == DATA_W'(SOFTRST_MAGIC);
      if (wr_en && sel == RS_LED)   led_q <= bus_wdata[LED_W-1:0];
      if (wr_en && sel == RS_BRK)   brk_q <= bus_wdata[BRK_W-1:0];
      if (wr_en && sel == RS_GPOUT) gpo_q <= bus_wdata[GPO_W-1:0];
    end
  end

  always_comb begin
    case (sel)
      RS_STATUS:  rd_mux = DATA_W'(STATUS_VAL);
      RS_LED:     rd_mux = DATA_W'(led_q);
      RS_BRK:     rd_mux = DATA_W'(brk_q);
      RS_GPOUT:   rd_mux = DATA_W'(gpo_q);
      RS_GPIN:    rd_mux = i2c_sel_w ? i2c_out_word : '0;
      RS_I2C_IN:  rd_mux = i2c_in_word;
      RS_I2C_OE:  rd_mux = DATA_W'(i2c_oe_w);
      RS_I2C_OUT: rd_mux = i2c_out_word;
      RS_I2C_SEL: rd_mux = DATA_W'(i2c_sel_w);
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= rd_en;
      if (rd_en) rdata_q <= rd_mux;
    end
  end

  assign bus_rvalid    = rvalid_q;
  assign bus_rdata     = rdata_q;
  assign sys_reset_req = rst_req_q;
  assign led_bar       = led_q;
  assign gp_out        = gpo_q;
  assign i2c_oe        = i2c_oe_w;

endmodule

// File: rtl/board_ctrl_sva.sv
module board_ctrl_sva
  import board_ctrl_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LED_W  = 8,
  parameter int GPO_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_rvalid,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              sys_reset_req,
  input logic [LED_W-1:0]  led_bar,
  input logic [GPO_W-1:0]  gp_out,
  input logic              i2c_scl,
  input logic              i2c_sda,
  input logic              i2c_update
);

  logic [OFF_W-1:0] off;
  logic             rd;
  logic             wr;

  assign off = bus_addr[OFF_W-1:0];
  assign rd  = bus_valid && !bus_write;
  assign wr  = bus_valid && bus_write;

  p_rsp_after_read_r1: assert property (@(posedge clk) disable iff (rst)
    rd |=> bus_rvalid);

  p_no_rsp_otherwise_r1: assert property (@(posedge clk) disable iff (rst)
    !rd |=> !bus_rvalid);

  p_switch_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (rd && off == OFF_W'(OFF_SWITCH)) |=> bus_rdata == '0);

  p_led_load_r5: assert property (@(posedge clk) disable iff (rst)
    (wr && off == OFF_W'(OFF_LED)) |=> led_bar == $past(bus_wdata[LED_W-1:0]));

  p_led_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !(wr && off == OFF_W'(OFF_LED)) |=> $stable(led_bar));

  p_softrst_cause_r8: assert property (@(posedge clk) disable iff (rst)
    sys_reset_req |-> $past(wr && off == OFF_W'(OFF_SOFTRST) &&
                            bus_wdata == DATA_W'(SOFTRST_MAGIC)));

  p_softrst_fire_r8: assert property (@(posedge clk) disable iff (rst)
    (wr && off == OFF_W'(OFF_SOFTRST) && bus_wdata == DATA_W'(SOFTRST_MAGIC))
      |=> sys_reset_req);

  p_gpout_load_r9: assert property (@(posedge clk) disable iff (rst)
    (wr && off == OFF_W'(OFF_GPOUT)) |=> gp_out == $past(bus_wdata[GPO_W-1:0]));

  p_i2c_lines_r10: assert property (@(posedge clk) disable iff (rst)
    i2c_update |-> {i2c_scl, i2c_sda} == $past(bus_wdata[1:0]));

endmodule

bind board_ctrl_regs board_ctrl_sva #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .LED_W  (LED_W),
  .GPO_W  (GPO_W)
) u_sva (
  .clk           (clk),
  .rst           (rst),
  .bus_valid     (bus_valid),
  .bus_write     (bus_write),
  .bus_addr      (bus_addr),
  .bus_wdata     (bus_wdata),
  .bus_rvalid    (bus_rvalid),
  .bus_rdata     (bus_rdata),
  .sys_reset_req (sys_reset_req),
  .led_bar       (led_bar),
  .gp_out        (gp_out),
  .i2c_scl       (i2c_scl),
  .i2c_sda       (i2c_sda),
  .i2c_update    (i2c_update)
);

// File: tb/board_ctrl_regs_tb_top.sv
`timescale 1ns/1ps
module board_ctrl_regs_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [31:0] bus_addr  = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rvalid;
  logic [31:0] bus_rdata;
  logic        sys_reset_req;
  logic [7:0]  led_bar;
  logic [7:0]  gp_out;
  logic [63:0] disp_text;
  logic        i2c_scl;
  logic        i2c_sda;
  logic [1:0]  i2c_oe;
  logic        i2c_update;
  logic        i2c_sda_in = 1'b1;

  always #2 clk = ~clk;

  board_ctrl_regs dut_i (
    .clk           (clk),
    .rst           (rst),
    .bus_valid     (bus_valid),
    .bus_write     (bus_write),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .bus_rvalid    (bus_rvalid),
    .bus_rdata     (bus_rdata),
    .sys_reset_req (sys_reset_req),
    .led_bar       (led_bar),
    .gp_out        (gp_out),
    .disp_text     (disp_text),
    .i2c_scl       (i2c_scl),
    .i2c_sda       (i2c_sda),
    .i2c_oe        (i2c_oe),
    .i2c_update    (i2c_update),
    .i2c_sda_in    (i2c_sda_in)
  );

  int          n_checks = 0;
  int          n_fails  = 0;
  bit          done     = 1'b0;
  logic [63:0] exp_q [$];
  string       tag_q [$];

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor: pops one expectation per read response.
  always @(negedge clk) begin
    if (!rst && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R1 response without read", 64'(bus_rdata), 64'h0);
      end else begin
        logic [63:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(64'(bus_rdata) == e, t, 64'(bus_rdata), e);
      end
    end
  end

  task automatic bus_wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [31:0] a, input logic [31:0] e,
                        input string tag);
    exp_q.push_back(64'(e));
    tag_q.push_back(tag);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  function automatic logic [63:0] hex_text(input logic [31:0] v);
    logic [63:0] r;
    for (int i = 0; i < 8; i++) begin
      logic [3:0] n;
      n = v[4*(7-i) +: 4];
      r[8*i +: 8] = (n < 10) ? (8'h30 + 8'(n)) : (8'h41 + 8'(n) - 8'd10);
    end
    return r;
  endfunction

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
  endtask

  initial begin
    #400000;
    if (!done) begin
      check(1'b0, "R1 watchdog expired", 64'h0, 64'h1);
      summary();
      $finish;
    end
  end

  initial begin
    logic [63:0] txt;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // Reset state at the ports
    check(led_bar == 8'h00, "R5 reset led_bar", 64'(led_bar), 64'h0);
    check(gp_out == 8'h00, "R9 reset gp_out", 64'(gp_out), 64'h0);
    check(disp_text == {8{8'h20}}, "R6 reset display", disp_text, {8{8'h20}});
    check(sys_reset_req == 1'b0, "R8 reset request idle", 64'(sys_reset_req), 64'h0);
    check({i2c_scl, i2c_sda} == 2'b11, "R10 reset i2c lines", 64'({i2c_scl, i2c_sda}), 64'h3);
    check(i2c_oe == 2'b00, "R12 reset i2c_oe", 64'(i2c_oe), 64'h0);

    // Reset state through reads
    bus_rd(32'h408, 32'h0, "R5 led reset read");
    bus_rd(32'h508, 32'h0A, "R9 brk reset read");
    bus_rd(32'hA00, 32'h0, "R9 gpout reset read");
    bus_rd(32'hB08, 32'h0, "R12 oe reset read");
    bus_rd(32'hB18, 32'h1, "R12 select reset read");
    bus_rd(32'hB10, 32'h3, "R10 i2c out reset read");
    bus_rd(32'hA08, 32'h3, "R13 gpin mirrors out");
    bus_rd(32'h208, 32'h12, "R4 status big-endian");
    bus_rd(32'h200, 32'h0, "R3 switch zero");
    bus_rd(32'h210, 32'h0, "R3 jumper zero");

    // LED bar and address aliasing
    bus_wr(32'h408, 32'h0000_01A5);
    check(led_bar == 8'hA5, "R5 led load", 64'(led_bar), 64'hA5);
    bus_rd(32'h408, 32'hA5, "R5 led readback");
    bus_wr(32'hABC0_0408, 32'h3C);
    check(led_bar == 8'h3C, "R2 aliased high bits", 64'(led_bar), 64'h3C);
    bus_wr(32'h404, 32'hFF);
    check(led_bar == 8'h3C, "R2 unmapped write ignored", 64'(led_bar), 64'h3C);
    bus_rd(32'h404, 32'h0, "R2 unmapped read zero");
    bus_rd(32'h7FFFC, 32'h0, "R2 unmapped high read zero");
    bus_wr(32'h200, 32'hFFFF_FFFF);
    bus_wr(32'h210, 32'hFFFF_FFFF);
    bus_rd(32'h200, 32'h0, "R3 switch after write");
    bus_rd(32'h210, 32'h0, "R3 jumper after write");

    // Display
    bus_wr(32'h410, 32'h1234_ABCD);
    check(disp_text == hex_text(32'h1234_ABCD), "R6 hex word 1234ABCD", disp_text, hex_text(32'h1234_ABCD));
    bus_wr(32'h410, 32'h00C0_FFEE);
    check(disp_text == hex_text(32'h00C0_FFEE), "R6 hex word 00C0FFEE", disp_text, hex_text(32'h00C0_FFEE));
    bus_wr(32'h418, 32'h78);
    txt = hex_text(32'h00C0_FFEE);
    txt[7:0] = 8'h78;
    check(disp_text == txt, "R7 char position 0", disp_text, txt);
    bus_wr(32'h450, 32'h0000_015A);
    txt[63:56] = 8'h5A;
    check(disp_text == txt, "R7 char position 7", disp_text, txt);
    bus_wr(32'h41C, 32'h21);
    check(disp_text == txt, "R7 misaligned char offset ignored", disp_text, txt);
    bus_rd(32'h418, 32'h0, "R7 char register reads zero");

    // Soft reset request
    bus_wr(32'h500, 32'h41);
    check(sys_reset_req == 1'b0, "R8 wrong value 41", 64'(sys_reset_req), 64'h0);
    bus_wr(32'h500, 32'h142);
    check(sys_reset_req == 1'b0, "R8 wrong value 142", 64'(sys_reset_req), 64'h0);
    bus_wr(32'h500, 32'h42);
    check(sys_reset_req == 1'b1, "R8 magic pulse", 64'(sys_reset_req), 64'h1);
    @(negedge clk);
    check(sys_reset_req == 1'b0, "R8 pulse one cycle", 64'(sys_reset_req), 64'h0);

    // Break and general-purpose output
    bus_wr(32'h508, 32'h1FF);
    bus_rd(32'h508, 32'hFF, "R9 brk 8 bits");
    bus_wr(32'hA00, 32'h5AA);
    check(gp_out == 8'hAA, "R9 gp_out port", 64'(gp_out), 64'hAA);
    bus_rd(32'hA00, 32'hAA, "R9 gpout readback");

    // I2C group
    bus_wr(32'hB10, 32'h0000_0002);
    check({i2c_scl, i2c_sda, i2c_update} == 3'b101, "R10 lines and update pulse",
          64'({i2c_scl, i2c_sda, i2c_update}), 64'h5);
    @(negedge clk);
    check(i2c_update == 1'b0, "R10 update one cycle", 64'(i2c_update), 64'h0);
    bus_wr(32'hB10, 32'hDEAD_BEE1);
    bus_rd(32'hB10, 32'hDEAD_BEE1, "R10 full word stored");
    bus_rd(32'hA08, 32'hDEAD_BEE1, "R13 gpin with select 1");
    bus_wr(32'hB18, 32'hFE);
    bus_rd(32'hB18, 32'h0, "R12 select cleared");
    bus_rd(32'hA08, 32'h0, "R13 gpin with select 0");
    bus_wr(32'hB18, 32'h3);
    bus_rd(32'hB18, 32'h1, "R12 select one bit");
    bus_wr(32'hB08, 32'hFF);
    check(i2c_oe == 2'b11, "R12 oe port", 64'(i2c_oe), 64'h3);
    bus_rd(32'hB08, 32'h3, "R12 oe two bits");
    i2c_sda_in = 1'b0;
    bus_rd(32'hB00, 32'h2, "R11 input sda low");
    i2c_sda_in = 1'b1;
    bus_rd(32'hB00, 32'h3, "R11 input sda high");

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R1 every read answered", 64'(exp_q.size()), 64'h0);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule